// File: doc/BRIEF.md
# Packed Float-to-Integer Truncating Converter

This block turns one 128-bit vector of floating-point values into a 128-bit vector of four 32-bit integers. It handles four single-precision lanes or two double-precision lanes, with a signed or an unsigned integer target. Every conversion rounds toward zero.

A policy bit chooses what happens to lanes that hold NaN or a value the target type cannot represent. One policy clamps such lanes to the nearest representable value. The other writes a fixed marker pattern. The datapath has two pipeline stages. It takes a new operand on every cycle and has no stall path.

Top module: `fp_trunc_vec`

## Requirements
- R1: Each lane is converted by discarding the fraction, rounding toward zero. Examples: 3.7 gives 3, -3.7 gives -3, -2.5 gives -2 (0xFFFFFFFE).
- R2: `in_op` encoding: 2'b00 = four single-precision lanes to signed, 2'b01 = four single-precision lanes to unsigned, 2'b10 = two double-precision lanes to signed, 2'b11 = two double-precision lanes to unsigned. For the single-precision forms, input bits [32i+31:32i] give result bits [32i+31:32i].
- R3: For the double-precision forms, input bits [64k+63:64k] (k = 0, 1) give result lane k, and result bits [127:64] are zero.
- R4: With `in_sat` = 0, a signed conversion returns 0x80000000 in any lane that holds NaN or a value outside the int32 range.
- R5: With `in_sat` = 0, an unsigned conversion returns 0xFFFFFFFF in any lane that holds NaN or a value outside the uint32 range. This includes negative values that truncate below zero.
- R6: With `in_sat` = 1, NaN lanes give 0. A signed target clamps to 0x7FFFFFFF or 0x80000000. An unsigned target clamps to 0xFFFFFFFF for values that are too large and to 0 for negative values.
- R7: Unsigned conversion is exact from 2^31 up to just below 2^32. Single 0x4F000001 gives 0x80000100, and single 0x4F7FFFFF gives 0xFFFFFF00.
- R8: Values -2^31 and a double that truncates to -2^31 are in range for a signed target and give 0x80000000. Zeros, denormals and values with magnitude below 1.0, of either sign, give 0 under both policies. Infinities are out of range, with their sign.
- R9: `out_valid` follows `in_valid` exactly two clock edges later, and the result belongs to that operand. Operands on consecutive cycles each produce their own result.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_vec` to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 2 | Conversion select (see R2) |
| in_sat | input | 1 | 1 = saturate, 0 = fixed marker pattern |
| in_vec | input | 128 | Packed floating-point operand |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 128 | Four packed 32-bit integer results |

## Verification
The hardest cases to reach are lanes that sit right at the edge of a range. Examples are a double whose fraction lies below -2^31 but truncates onto it, single values just above 2^31 that only the unsigned form must keep exactly, and negatives in (-1, 0) that must not count as overflow for an unsigned target. The bench builds these operands bit by bit from hand-derived encodings, puts them in different lanes of the same vector, and runs each one under both policies. It also sends a back-to-back stream that mixes operation codes, to show that the two stages never blend neighbouring operands.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int LANES = 4;
  localparam int LW    = 32;
  localparam int VW    = LANES * LW;

  typedef enum logic [1:0] {
    OP_SP_SGN = 2'b00,
    OP_SP_UNS = 2'b01,
    OP_DP_SGN = 2'b10,
    OP_DP_UNS = 2'b11
  } conv_op_e;

  // neg: sign bit, nan: not-a-number, huge: |x| >= 2^32 or infinite,
  // mag: truncated magnitude (meaningful when neither nan nor huge)
  typedef struct packed {
    logic          neg;
    logic          nan;
    logic          huge;
    logic [LW-1:0] mag;
  } lane_dec_t;

  function automatic logic lane_oor(lane_dec_t d, logic uns);
    logic res;
    if (uns) res = d.huge || (d.neg && (d.mag != '0));
    else     res = d.huge || (d.mag[LW-1] && !(d.neg && d.mag == {1'b1, {(LW-1){1'b0}}}));
    return res;
  endfunction

  function automatic logic [LW-1:0] finish_lane(lane_dec_t d, logic uns, logic sat);
    logic [LW-1:0] r;
    if (d.nan) begin
      r = sat ? '0 : (uns ? '1 : {1'b1, {(LW-1){1'b0}}});
    end else if (lane_oor(d, uns)) begin
      if (!sat)    r = uns ? '1 : {1'b1, {(LW-1){1'b0}}};
      else if (uns) r = d.neg ? '0 : '1;
      else         r = d.neg ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
    end else begin
      r = (!uns && d.neg) ? (~d.mag + 1'b1) : d.mag;
    end
    return r;
  endfunction
endpackage

// File: rtl/ftc_lane_decode.sv
module ftc_lane_decode
  import ftc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fbits,
  output lane_dec_t            dec
);
  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam int SW   = MAN_W + 1 + LW;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             below_one;
  logic [EXP_W:0]   e_unb;
  logic             too_big;
  logic [SW-1:0]    sig_ext;
  logic [SW-1:0]    shifted;

  assign exp_f     = fbits[EXP_W+MAN_W-1:MAN_W];
  assign man_f     = fbits[MAN_W-1:0];
  assign exp_max   = &exp_f;
  assign below_one = {1'b0, exp_f} < BIAS[EXP_W:0];
  assign e_unb     = {1'b0, exp_f} - BIAS[EXP_W:0];
  assign too_big   = exp_max || (!below_one && e_unb >= (EXP_W+1)'(LW));
  assign sig_ext   = {{LW{1'b0}}, 1'b1, man_f};

  always_comb begin
    if (e_unb <= MAN_W[EXP_W:0]) shifted = sig_ext >> (MAN_W[EXP_W:0] - e_unb);
    else                         shifted = sig_ext << (e_unb - MAN_W[EXP_W:0]);
  end

  always_comb begin
    dec.neg  = fbits[EXP_W+MAN_W];
    dec.nan  = exp_max && (man_f != '0);
    dec.huge = too_big;
    dec.mag  = (below_one || too_big) ? '0 : shifted[LW-1:0];
  end

  always_comb begin
    if (!below_one && !too_big)
      AST_NO_LOST_BITS: assert (shifted[SW-1:LW] == '0); // R7
  end
endmodule

// File: rtl/ftc_lane_finish.sv
module ftc_lane_finish
  import ftc_pkg::*;
(
  input  lane_dec_t     dec,
  input  logic          uns,
  input  logic          sat,
  input  logic          zero_lane,
  output logic [LW-1:0] res,
  output logic          oor
);
  assign oor = !zero_lane && !dec.nan && lane_oor(dec, uns);
  assign res = zero_lane ? '0 : finish_lane(dec, uns, sat);

  always_comb begin
    if (!zero_lane && !dec.nan && !dec.huge && dec.mag == '0)
      AST_SMALL_IS_ZERO: assert (res == '0); // R8
  end
endmodule

// File: rtl/fp_trunc_vec.sv
module fp_trunc_vec
  import ftc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic          in_sat,
  input  logic [VW-1:0] in_vec,
  output logic          out_valid,
  output logic [VW-1:0] out_vec
);
  localparam int DP_LANES = LANES / 2;

  lane_dec_t sp_dec [LANES];
  lane_dec_t dp_dec [DP_LANES];
  lane_dec_t sel_dec [LANES];

  logic            s1_valid;
  logic [1:0]      s1_op;
  logic            s1_sat;
  lane_dec_t       s1_dec [LANES];
  logic [LW-1:0]   lane_res [LANES];
  logic [LANES-1:0] s1_oor;
  logic [LANES-1:0] s1_nan;
  logic            out_dp;

  for (genvar i = 0; i < LANES; i++) begin : g_sp
    ftc_lane_decode #(.EXP_W(8), .MAN_W(23)) u_dec (
      .fbits(in_vec[LW*i +: LW]),
      .dec  (sp_dec[i])
    );
  end

  for (genvar k = 0; k < DP_LANES; k++) begin : g_dp
    ftc_lane_decode #(.EXP_W(11), .MAN_W(52)) u_dec (
      .fbits(in_vec[2*LW*k +: 2*LW]),
      .dec  (dp_dec[k])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_sel
    if (i < DP_LANES) begin : g_lo
      assign sel_dec[i] = in_op[1] ? dp_dec[i] : sp_dec[i];
    end else begin : g_hi
      assign sel_dec[i] = in_op[1] ? '0 : sp_dec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_SP_SGN;
      s1_sat   <= 1'b0;
      for (int i = 0; i < LANES; i++) s1_dec[i] <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_op    <= in_op;
      s1_sat   <= in_sat;
      for (int i = 0; i < LANES; i++) s1_dec[i] <= sel_dec[i];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_fin
    ftc_lane_finish u_fin (
      .dec      (s1_dec[i]),
      .uns      (s1_op[0]),
      .sat      (s1_sat),
      .zero_lane(s1_op[1] && (i >= DP_LANES)),
      .res      (lane_res[i]),
      .oor      (s1_oor[i])
    );
    assign s1_nan[i] = s1_dec[i].nan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_dp    <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_dp    <= s1_op[1];
      for (int i = 0; i < LANES; i++) out_vec[LW*i +: LW] <= lane_res[i];
    end
  end

  AST_FILL: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R9
  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R9
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid); // R9
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dp) |-> (out_vec[VW-1:VW/2] == '0)); // R3
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0)); // R10

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_NAN_MARK: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_nan[i] && !s1_sat) |=>
      (out_vec[LW*i +: LW] == ($past(s1_op[0]) ? 32'hFFFF_FFFF : 32'h8000_0000))); // R4
    AST_NAN_SAT: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_nan[i] && s1_sat) |=> (out_vec[LW*i +: LW] == '0)); // R6
    AST_OOR_MARK: assert property (@(posedge clk) disable iff (rst)
      (s1_valid && s1_oor[i] && !s1_sat && s1_op[0]) |=>
      (out_vec[LW*i +: LW] == 32'hFFFF_FFFF)); // R5
  end
endmodule

// File: tb/fp_trunc_vec_tb.sv
module fp_trunc_vec_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   in_op;
  logic         in_sat;
  logic [127:0] in_vec;
  logic         out_valid;
  logic [127:0] out_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_trunc_vec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_sat(in_sat), .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec)
  );

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operand, confirm nothing appears after one edge, result after two
  task automatic conv(input logic [1:0] op, input logic sat, input logic [127:0] v,
                      input logic [127:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_sat = sat; in_vec = v;
    @(negedge clk);
    in_valid = 1'b0; in_vec = '0;
    check({127'd0, out_valid}, 128'd0, {tag, " R9 early"});
    @(negedge clk);
    check({127'd0, out_valid}, 128'd1, {tag, " R9 valid"});
    check(out_vec, exp, tag);
  endtask

  task automatic t_reset;
    check({127'd0, out_valid}, 128'd0, "R10 valid after reset");
    check(out_vec, 128'd0, "R10 vector after reset");
  endtask

  task automatic t_sp_signed_basic;
    conv(2'b00, 1'b0, {32'hC0200000, 32'h47F12065, 32'hC06CCCCD, 32'h406CCCCD},
         {32'hFFFFFFFE, 32'h0001E240, 32'hFFFFFFFD, 32'h00000003}, "R1 R2 single signed");
    conv(2'b00, 1'b1, {32'h3F800000, 32'hC0200000, 32'h42C90000, 32'hBF800000},
         {32'h00000001, 32'hFFFFFFFE, 32'h00000064, 32'hFFFFFFFF}, "R2 lane order");
  endtask

  task automatic t_sp_signed_range;
    conv(2'b00, 1'b0, {32'hFF800000, 32'h7F800000, 32'h7FC00000, 32'h4F000000},
         {4{32'h80000000}}, "R4 single signed marker");
    conv(2'b00, 1'b1, {32'hFF800000, 32'h7F800000, 32'h7FC00000, 32'h4F000000},
         {32'h80000000, 32'h7FFFFFFF, 32'h00000000, 32'h7FFFFFFF}, "R6 single signed clamp");
  endtask

  task automatic t_sp_unsigned;
    conv(2'b01, 1'b0, {32'h42C90000, 32'h4F7FFFFF, 32'h4F000001, 32'h4F000000},
         {32'h00000064, 32'hFFFFFF00, 32'h80000100, 32'h80000000}, "R7 unsigned upper half");
    conv(2'b01, 1'b0, {32'hFF800000, 32'h7FC00000, 32'h4F800000, 32'hBF800000},
         {4{32'hFFFFFFFF}}, "R5 single unsigned marker");
    conv(2'b01, 1'b1, {32'hFF800000, 32'h7FC00000, 32'h4F800000, 32'hBF800000},
         {32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}, "R6 single unsigned clamp");
  endtask

  task automatic t_sp_edges;
    conv(2'b00, 1'b0, {32'h80000000, 32'h00000001, 32'hBF000000, 32'hCF000000},
         {32'h0, 32'h0, 32'h0, 32'h80000000}, "R8 single signed edges");
    conv(2'b01, 1'b0, {32'h3F800000, 32'h80000000, 32'h00000001, 32'hBF000000},
         {32'h1, 32'h0, 32'h0, 32'h0}, "R8 single unsigned small");
  endtask

  task automatic t_dp;
    conv(2'b10, 1'b0, {64'hC01E000000000000, 64'h400D99999999999A},
         {64'd0, 32'hFFFFFFF9, 32'h00000003}, "R3 R1 double signed");
    conv(2'b10, 1'b0, {64'h41E0000000000000, 64'hC1E0000000180000},
         {64'd0, 32'h80000000, 32'h80000000}, "R4 R8 double signed marker");
    conv(2'b10, 1'b1, {64'h41E0000000000000, 64'hC1E0000000180000},
         {64'd0, 32'h7FFFFFFF, 32'h80000000}, "R6 R8 double signed clamp");
    conv(2'b11, 1'b0, {64'hBFD0000000000000, 64'h41EFFFFFFFF00000},
         {64'd0, 32'h00000000, 32'hFFFFFFFF}, "R7 R8 double unsigned");
    conv(2'b11, 1'b0, {64'h7FF8000000000000, 64'h4202A05F20000000},
         {64'd0, 32'hFFFFFFFF, 32'hFFFFFFFF}, "R5 double unsigned marker");
    conv(2'b11, 1'b1, {64'hC01E000000000000, 64'h4202A05F20000000},
         {64'd0, 32'h00000000, 32'hFFFFFFFF}, "R6 double unsigned clamp");
    conv(2'b11, 1'b1, {64'h7FF8000000000000, 64'h3FF0000000000000},
         {64'd0, 32'h00000000, 32'h00000001}, "R6 double NaN clamp");
  endtask

  task automatic t_stream;
    logic [1:0]   ops [3];
    logic [127:0] vs  [3];
    logic [127:0] es  [3];
    ops[0] = 2'b00; vs[0] = {32'h406CCCCD, 32'h3F800000, 32'h42C90000, 32'hC0200000};
    es[0] = {32'h3, 32'h1, 32'h64, 32'hFFFFFFFE};
    ops[1] = 2'b11; vs[1] = {64'h3FF0000000000000, 64'h41EFFFFFFFF00000};
    es[1] = {64'd0, 32'h1, 32'hFFFFFFFF};
    ops[2] = 2'b01; vs[2] = {32'h4F000001, 32'h4F000001, 32'h4F000001, 32'h4F000001};
    es[2] = {4{32'h80000100}};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2 && k < 5) begin
        check({127'd0, out_valid}, 128'd1, "R9 stream valid");
        check(out_vec, es[k-2], "R9 stream data");
      end else begin
        check({127'd0, out_valid}, 128'd0, "R9 stream idle");
      end
      if (k < 3) begin
        in_valid = 1'b1; in_op = ops[k]; in_sat = 1'b0; in_vec = vs[k];
      end else begin
        in_valid = 1'b0; in_vec = '0;
      end
    end
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b00; in_sat = 1'b0; in_vec = {4{32'h3F800000}};
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({127'd0, out_valid}, 128'd0, "R10 valid after mid reset");
    check(out_vec, 128'd0, "R10 vector after mid reset");
    @(negedge clk);
    check({127'd0, out_valid}, 128'd0, "R10 flushed operand");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_sat = 1'b0; in_vec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sp_signed_basic();
    t_sp_signed_range();
    t_sp_unsigned();
    t_sp_edges();
    t_dp();
    t_stream();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule